// File: doc/BRIEF.md
# Six-Pin Port with Pairwise Address-Bus Handover

This block is a small general-purpose I/O port of six pins that software reaches through byte-wide register accesses. Each pin can be a plain input or a plain output, and its direction is chosen on its own. Any pair of neighbouring pins can also be handed over to an external memory bus controller. A handed-over pin then drives one of the upper address lines, bits 16 to 21, instead of its port value.

Three registers sit behind a two-bit register select: an output latch, a direction register and a function-select register with one bit per pin pair. The port is narrower than the access width. The bits above the implemented pins are therefore dropped on writes and read back as zero. The pads are modelled as separate out, output-enable and in signals. Writes are sampled on the rising clock edge, and reads are combinational.

Top module: `pairsel_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, the output latch, direction register and function-select register are all cleared. After that edge every pin is a port-mode input with `pad_oe` low, and reads of the direction and function-select registers return 0.
- R2: `reg_sel` selects the register: 0 is the output latch / pin data, 1 is direction, 2 is function select and 3 is unused. Reads of select 3 return 0. Writes to select 3 change no pad output and no register.
- R3: On a write to the data or direction register, `wr_data` bits 7 and 6 are discarded. On a write to function select, only bits 2..0 are kept. Every read returns 0 in the bits above the implemented fields.
- R4: A pin in port mode whose direction bit is 1 drives `pad_oe` high. A pin in port mode whose direction bit is 0 drives `pad_oe` low. In port mode `pad_out` carries the output latch bit of the pin.
- R5: Reading register 0 returns, for each port-mode pin, its latch bit if the pin is an output and its `pad_in` level if the pin is an input.
- R6: Function-select bit k puts pins 2k and 2k+1 together into control mode (1) or port mode (0).
- R7: A pin in control mode drives `pad_oe` high and drives `pad_out` with `ctl_addr` bit i, which is address bit 16+i. Its direction bit has no effect on the pad but still reads back unchanged.
- R8: Writes to register 0 update the output latch of every pin, whether the pin is an input or in control mode. The stored value appears on `pad_out` once the pin becomes a port-mode output.
- R9: Reading register 0 returns the `pad_in` level for a pin in control mode.
- R10: A register write takes effect at the rising edge where `wr_en` is high. The pad outputs show the new value after that edge and not before it. `rd_data` follows `reg_sel` and `pad_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 function, 3 unused |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational |
| ctl_addr | input | 6 | Upper address bits 16..21 from the bus controller |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables, 1 = drive |

## Verification
The bench builds the port with its default parameters: six pins, pin groups of two and an eight-bit access width. With these values two bus bits lie above the pins, so the masking of bits 7 and 6 and the zero read-back can be observed directly. The three pin pairs also allow mixed patterns, with control-mode pairs placed next to port-mode pairs, and with the direction bits set against the function selection. The R8 latch-shadowing case is checked by writing data while pins are inputs or handed over, then switching the same pins back to port-mode outputs.

// File: rtl/pairsel_pkg.sv
// Package pairsel_pkg
// Purpose: shared register-select encoding for the six-pin port.
// Assumes: a two-bit select field on the register interface.
package pairsel_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_FUNC = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pairsel_regs.sv
// Module pairsel_regs
// Purpose: holds the output latch, the direction register and the per-group
//          function-select register, all loaded from byte-wide writes.
// Assumes: PINS and GROUPS are not wider than BUS_W; bits of wr_data above
//          each register's width are dropped; synchronous active-low reset.
module pairsel_regs
    import pairsel_pkg::*;
#(
    parameter int PINS       = 6,
    parameter int GROUP_SIZE = 2,
    parameter int BUS_W      = 8,
    localparam int GROUPS    = PINS / GROUP_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [PINS-1:0]   out_latch,
    output logic [PINS-1:0]   dir_q,
    output logic [GROUPS-1:0] func_q
);

    logic wr_data_hit;
    logic wr_dir_hit;
    logic wr_func_hit;
    logic unused_wr_bits;

    // Decode which register the current write targets.
    always_comb begin
        wr_data_hit = wr_en && (reg_sel_e'(reg_sel) == SEL_DATA);
        wr_dir_hit  = wr_en && (reg_sel_e'(reg_sel) == SEL_DIR);
        wr_func_hit = wr_en && (reg_sel_e'(reg_sel) == SEL_FUNC);
    end

    // Bits above the register widths are dropped on purpose.
    assign unused_wr_bits = ^wr_data;

    // Output latch: loaded on every data write, whatever the pin state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch <= '0;
        end else if (wr_data_hit) begin
            out_latch <= wr_data[PINS-1:0];
        end
    end

    // Direction register: one bit per pin, 1 selects output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir_hit) begin
            dir_q <= wr_data[PINS-1:0];
        end
    end

    // Function select: one bit per pin group, 1 hands the group to the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
        end else if (wr_func_hit) begin
            func_q <= wr_data[GROUPS-1:0];
        end
    end

endmodule

// File: rtl/pairsel_pinmux.sv
// Module pairsel_pinmux
// Purpose: per-pin selection between port function and address output, and
//          the per-pin value seen by a data-register read.
// Assumes: pin i of group g is pin g*GROUP_SIZE+i; ctl_addr bit i is the
//          address line that pin i drives in control mode.
module pairsel_pinmux #(
    parameter int PINS       = 6,
    parameter int GROUP_SIZE = 2,
    localparam int GROUPS    = PINS / GROUP_SIZE
) (
    input  logic [PINS-1:0]   out_latch,
    input  logic [PINS-1:0]   dir_q,
    input  logic [GROUPS-1:0] func_q,
    input  logic [PINS-1:0]   ctl_addr,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pin_view,
    output logic [PINS-1:0]   ctrl_mask
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_pin
            localparam int P = g * GROUP_SIZE + i;

            // Spread the group's function bit to each of its pins.
            assign ctrl_mask[P] = func_q[g];

            // Choose pad drive: address line in control mode, latch otherwise.
            always_comb begin
                if (func_q[g]) begin
                    pad_out[P] = ctl_addr[P];
                    pad_oe[P]  = 1'b1;
                end else begin
                    pad_out[P] = out_latch[P];
                    pad_oe[P]  = dir_q[P];
                end
            end

            // Readback: latch for port outputs, pad level for the rest.
            always_comb begin
                if (!func_q[g] && dir_q[P]) begin
                    pin_view[P] = out_latch[P];
                end else begin
                    pin_view[P] = pad_in[P];
                end
            end
        end
    end

endmodule

// File: rtl/pairsel_readback.sv
// Module pairsel_readback
// Purpose: combinational read multiplexer, zero-extended to the bus width.
// Assumes: select 3 is unused and reads as zero.
module pairsel_readback
    import pairsel_pkg::*;
#(
    parameter int PINS       = 6,
    parameter int GROUP_SIZE = 2,
    parameter int BUS_W      = 8,
    localparam int GROUPS    = PINS / GROUP_SIZE
) (
    input  logic [1:0]        reg_sel,
    input  logic [PINS-1:0]   pin_view,
    input  logic [PINS-1:0]   dir_q,
    input  logic [GROUPS-1:0] func_q,
    output logic [BUS_W-1:0]  rd_data
);

    // Select the addressed field; untouched upper bits stay zero.
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(reg_sel))
            SEL_DATA: rd_data[PINS-1:0]   = pin_view;
            SEL_DIR:  rd_data[PINS-1:0]   = dir_q;
            SEL_FUNC: rd_data[GROUPS-1:0] = func_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pairsel_port.sv
// Module pairsel_port
// Purpose: six-pin I/O port whose pin pairs can be handed to the upper
//          address lines of an external memory bus.
// Assumes: PINS is a multiple of GROUP_SIZE and not wider than BUS_W.
module pairsel_port #(
    parameter int PINS       = 6,
    parameter int GROUP_SIZE = 2,
    parameter int BUS_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    input  logic [PINS-1:0]  ctl_addr,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe
);

    localparam int GROUPS = PINS / GROUP_SIZE;

    logic [PINS-1:0]   out_latch;
    logic [PINS-1:0]   dir_q;
    logic [GROUPS-1:0] func_q;
    logic [PINS-1:0]   pin_view;
    logic [PINS-1:0]   ctrl_mask;

    pairsel_regs #(
        .PINS(PINS), .GROUP_SIZE(GROUP_SIZE), .BUS_W(BUS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .out_latch(out_latch), .dir_q(dir_q),
        .func_q(func_q)
    );

    pairsel_pinmux #(
        .PINS(PINS), .GROUP_SIZE(GROUP_SIZE)
    ) u_mux (
        .out_latch(out_latch), .dir_q(dir_q), .func_q(func_q),
        .ctl_addr(ctl_addr), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pin_view(pin_view), .ctrl_mask(ctrl_mask)
    );

    pairsel_readback #(
        .PINS(PINS), .GROUP_SIZE(GROUP_SIZE), .BUS_W(BUS_W)
    ) u_rd (
        .reg_sel(reg_sel), .pin_view(pin_view), .dir_q(dir_q),
        .func_q(func_q), .rd_data(rd_data)
    );

endmodule

// File: rtl/pairsel_port_chk.sv
// Module pairsel_port_chk
// Purpose: temporal checks on the port, attached to every pairsel_port.
// Assumes: ctrl_mask is the per-pin control-mode view inside the top.
module pairsel_port_chk
    import pairsel_pkg::*;
#(
    parameter int PINS       = 6,
    parameter int GROUP_SIZE = 2,
    parameter int BUS_W      = 8,
    localparam int GROUPS    = PINS / GROUP_SIZE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       reg_sel,
    input logic [BUS_W-1:0] wr_data,
    input logic [BUS_W-1:0] rd_data,
    input logic [PINS-1:0]  ctl_addr,
    input logic [PINS-1:0]  pad_out,
    input logic [PINS-1:0]  pad_oe,
    input logic [PINS-1:0]  ctrl_mask
);

    function automatic logic [PINS-1:0] spread(input logic [GROUPS-1:0] f);
        logic [PINS-1:0] m;
        m = '0;
        for (int p = 0; p < PINS; p++) m[p] = f[p / GROUP_SIZE];
        return m;
    endfunction

    // R1: a reset edge leaves every pad undriven.
    assert_reset_undriven_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0));

    // R2: writes to the unused select leave the pads alone.
    assert_unused_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R3: bits above the pin field never read back set.
    if (PINS < BUS_W) begin : g_upper
        assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[BUS_W-1:PINS] == '0);
    end

    // R4: with no group handed over, a direction write lands on pad_oe.
    assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1 && ctrl_mask == '0)
        |=> (pad_oe == $past(wr_data[PINS-1:0])));

    // R6: a function write selects whole pin pairs.
    assert_pair_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2)
        |=> (ctrl_mask == spread($past(wr_data[GROUPS-1:0]))));

    // R7: handed-over pins drive the address lines.
    assert_ctrl_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ctrl_mask) == ctrl_mask)
        && (((pad_out ^ ctl_addr) & ctrl_mask) == '0));

endmodule

bind pairsel_port pairsel_port_chk #(
    .PINS(PINS), .GROUP_SIZE(GROUP_SIZE), .BUS_W(BUS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .ctl_addr(ctl_addr),
    .pad_out(pad_out), .pad_oe(pad_oe), .ctrl_mask(ctrl_mask)
);

// File: tb/pairsel_port_bench.sv
`timescale 1ns/1ps
module pairsel_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [5:0] ctl_addr = 6'h00;
    logic [5:0] pad_in = 6'h00;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pairsel_port u_pairsel_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .ctl_addr(ctl_addr),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        wr(2'd0, 8'h3F);
        wr(2'd1, 8'h3F);
        wr(2'd2, 8'h07);
        do_reset();
        chk("R1", "pad_oe after reset", {2'b00, pad_oe}, 8'h00);
        rd(2'd1, v); chk("R1", "dir after reset", v, 8'h00);
        rd(2'd2, v); chk("R1", "func after reset", v, 8'h00);
        pad_in = 6'h2A;
        rd(2'd0, v); chk("R1", "data reads pads after reset", v, 8'h2A);
        wr(2'd1, 8'h3F);
        chk("R1", "latch cleared by reset", {2'b00, pad_out}, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_write_mask();
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        rd(2'd0, v); chk("R3", "data high bits dropped", v, 8'h3F);
        rd(2'd1, v); chk("R3", "dir high bits dropped", v, 8'h3F);
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk("R3", "func keeps three bits", v, 8'h07);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_port_dir();
        wr(2'd0, 8'h2A);
        @(negedge clk);
        reg_sel = 2'd1;
        wr_data = 8'h15;
        wr_en = 1'b1;
        #2.0;
        chk("R10", "pad_oe before write edge", {2'b00, pad_oe}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10", "pad_oe after write edge", {2'b00, pad_oe}, 8'h15);
        chk("R4", "port pad_oe follows dir", {2'b00, pad_oe}, 8'h15);
        chk("R4", "port pad_out is latch", {2'b00, pad_out}, 8'h2A);
    endtask

    task automatic t_port_read();
        logic [7:0] v;
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h05);
        pad_in = 6'h30;
        rd(2'd0, v); chk("R5", "mixed read pattern A", v, 8'h35);
        pad_in = 6'h1F;
        rd(2'd0, v); chk("R5", "mixed read pattern B", v, 8'h15);
        pad_in = 6'h2F;
        rd(2'd0, v); chk("R10", "read follows pad_in same cycle", v, 8'h25);
    endtask

    task automatic t_pair_select();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        ctl_addr = 6'h2C;
        wr(2'd2, 8'h02);
        chk("R6", "group 1 pad_oe", {2'b00, pad_oe}, 8'h0C);
        chk("R7", "group 1 drives address", {2'b00, pad_out}, 8'h0C);
        wr(2'd1, 8'h3F);
        chk("R7", "dir ignored, pad_oe", {2'b00, pad_oe}, 8'h3F);
        ctl_addr = 6'h13;
        #1;
        chk("R7", "address change seen", {2'b00, pad_out}, 8'h00);
        rd(2'd1, v); chk("R7", "dir still reads back", v, 8'h3F);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h05);
        ctl_addr = 6'h21;
        #1;
        chk("R6", "groups 0 and 2 pad_oe", {2'b00, pad_oe}, 8'h33);
        chk("R7", "groups 0 and 2 drive address", {2'b00, pad_out}, 8'h21);
        wr(2'd1, 8'h3F);
        wr(2'd0, 8'h3F);
        pad_in = 6'h01;
        rd(2'd0, v); chk("R9", "control pins read pads", v, 8'h0D);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_latch_shadow();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h25);
        pad_in = 6'h00;
        rd(2'd0, v); chk("R8", "input pins hide latch", v, 8'h00);
        wr(2'd1, 8'h3F);
        chk("R8", "latch appears on output", {2'b00, pad_out}, 8'h25);
        wr(2'd2, 8'h07);
        ctl_addr = 6'h00;
        wr(2'd0, 8'h1A);
        #1;
        chk("R8", "control mode hides latch", {2'b00, pad_out}, 8'h00);
        wr(2'd2, 8'h00);
        chk("R8", "latch written in control mode", {2'b00, pad_out}, 8'h1A);
    endtask

    task automatic t_unused_sel();
        logic [7:0] v;
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h05);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R2", "unused select reads zero", v, 8'h00);
        chk("R2", "pad_oe untouched", {2'b00, pad_oe}, 8'h0F);
        chk("R2", "pad_out untouched", {2'b00, pad_out}, 8'h05);
        rd(2'd2, v); chk("R2", "func untouched", v, 8'h00);
        rd(2'd1, v); chk("R2", "dir untouched", v, 8'h0F);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        do_reset();
        t_reset();
        t_write_mask();
        t_port_dir();
        t_port_read();
        t_pair_select();
        t_latch_shadow();
        t_unused_sel();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule